// File: doc/BRIEF.md
# Completion Pointer Interrupt Tracker

This block keeps one completion pointer per receive channel of a DMA engine and turns the pointers into a single level interrupt for the host. When the DMA side finishes a packet, it writes the address of the last buffer descriptor it used into the channel's slot. That write marks the channel pending, provided the channel's enable bit is set. The value written plays no part in this.

The host acknowledges by writing back the descriptor address it has finished with. The block only compares that value with the stored pointer and never stores it. On a match the channel's pending bit clears. On a mismatch the bit stays set, because the DMA side has completed more packets than the host has handled. The host may acknowledge every packet or batch several packets into one acknowledge.

The combined output is the OR of the enabled pending bits, passed through an arming gate. Once the output has been high and then falls, the gate closes. It stays closed until software writes the end-of-interrupt key.

Top module: `cpi_tracker`

## Requirements
- R1: After reset every stored pointer reads 0, all pending bits and all enable bits are 0, `irq` is 0 and the gate is armed.
- R2: A DMA write to channel c stores `dma_wr_ptr`. Reading channel c through `rd_ch`/`rd_ptr` returns that value from the next cycle.
- R3: A DMA write to a channel whose enable bit is 1 sets that channel's bit in `pend_raw` on the next cycle, whatever the written value, including a repeat of the stored value.
- R4: A DMA write to a channel whose enable bit is 0 still stores the pointer but leaves a clear pending bit clear.
- R5: An acknowledge whose value equals the channel's stored pointer clears that channel's pending bit on the next cycle, and the stored pointer is unchanged.
- R6: An acknowledge whose value differs from the stored pointer leaves both the pending bit and the stored pointer unchanged.
- R7: When a DMA write and an acknowledge hit the same channel in one cycle, the DMA write takes effect (new pointer, pending set if enabled) and the acknowledge is dropped.
- R8: Enable bits are set by `mask_set_bits` (write-one-to-set) and cleared by `mask_clr_bits` (write-one-to-clear). A bit named in both in one cycle ends up 0. Changing an enable bit never alters `pend_raw`.
- R9: `irq` equals the armed gate ANDed with the OR over channels of (`pend_raw` AND `mask_bits`).
- R10: The gate disarms at the end of any cycle in which `irq` is 0 after having been 1 in the previous cycle. While the gate is disarmed, `irq` stays 0 whatever is pending. An end-of-interrupt write carrying any key other than `EOI_KEY` (default 8'h01) has no effect.
- R11: An end-of-interrupt write carrying `EOI_KEY` arms the gate on the next cycle, so `irq` then rises at once if any enabled channel is pending. This write takes priority over a disarm in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_wr_en | input | 1 | DMA-side completion write strobe |
| dma_wr_ch | input | CH_W | Channel addressed by the DMA write |
| dma_wr_ptr | input | PTR_W | Last descriptor address used by the DMA |
| ack_wr_en | input | 1 | Host acknowledge strobe |
| ack_wr_ch | input | CH_W | Channel being acknowledged |
| ack_wr_ptr | input | PTR_W | Last descriptor address processed by the host |
| rd_ch | input | CH_W | Channel selected for pointer read-back |
| rd_ptr | output | PTR_W | Stored pointer of the selected channel |
| mask_set_en | input | 1 | Strobe for the write-one-to-set enable register |
| mask_set_bits | input | NUM_CH | Enable bits to set |
| mask_clr_en | input | 1 | Strobe for the write-one-to-clear enable register |
| mask_clr_bits | input | NUM_CH | Enable bits to clear |
| eoi_wr_en | input | 1 | End-of-interrupt write strobe |
| eoi_key | input | KEY_W | Key carried by the end-of-interrupt write |
| pend_raw | output | NUM_CH | Per-channel pending bits before masking |
| mask_bits | output | NUM_CH | Current per-channel enable bits |
| irq | output | 1 | Combined, gated interrupt level |

## Verification
A wrong comparison or a lost pointer shows up on `pend_raw` the cycle after the acknowledge: the bit either stays set when it should clear or clears early. A corrupted pointer is also visible on `rd_ptr` in the same cycle. A wrong arming state appears as `irq` rising while disarmed, or staying low after the correct key, one cycle after the triggering write. The bench keeps its own per-channel model of pointers, pending bits, enables and gate state. It compares all outputs after every edge, so any divergence is caught at the first cycle where it reaches a port.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
   // Operation applied to one channel slot in a given cycle.
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_DMA  = 2'd1,
      SLOT_ACK  = 2'd2
   } slot_op_e;
endpackage

// File: rtl/cpi_chan_slot.sv
module cpi_chan_slot
   import cpi_pkg::*;
#(
   parameter int PTR_W = 32,
   parameter int CH_W  = 3,
   parameter int IDX   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_en,
   input  logic [CH_W-1:0]  dma_ch,
   input  logic [PTR_W-1:0] dma_ptr,
   input  logic             ack_en,
   input  logic [CH_W-1:0]  ack_ch,
   input  logic [PTR_W-1:0] ack_ptr,
   input  logic             enable,
   output logic [PTR_W-1:0] ptr_q,
   output logic             pend_q
);
   localparam logic [CH_W-1:0] MY_CH = CH_W'(IDX);

   logic     dma_hit;
   logic     ack_hit;
   slot_op_e op;

   assign dma_hit = dma_en && (dma_ch == MY_CH);
   assign ack_hit = ack_en && (ack_ch == MY_CH);

   // DMA write has priority over a same-cycle acknowledge.
   always_comb begin
      if (dma_hit)      op = SLOT_DMA;
      else if (ack_hit) op = SLOT_ACK;
      else              op = SLOT_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         case (op)
            SLOT_DMA: begin
               ptr_q <= dma_ptr;
               if (enable) pend_q <= 1'b1;
            end
            SLOT_ACK: begin
               if (ack_ptr == ptr_q) pend_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   p_dma_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hit |=> ptr_q == $past(dma_ptr));
   p_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hit && enable |=> pend_q);
   p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hit && !enable && !pend_q |=> !pend_q);
   p_ack_keeps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit && !dma_hit |=> $stable(ptr_q));
   p_ack_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit && !dma_hit && (ack_ptr == ptr_q) |=> !pend_q);
   p_ack_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit && !dma_hit && (ack_ptr != ptr_q) && pend_q |=> pend_q);
   p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hit && ack_hit && pend_q |=> pend_q);
endmodule

// File: rtl/cpi_mask_reg.sv
module cpi_mask_reg #(
   parameter int NUM_CH    = 8,
   parameter bit CLR_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [NUM_CH-1:0] set_bits,
   input  logic              clr_en,
   input  logic [NUM_CH-1:0] clr_bits,
   output logic [NUM_CH-1:0] mask_q
);
   logic [NUM_CH-1:0] set_v;
   logic [NUM_CH-1:0] clr_v;
   logic [NUM_CH-1:0] mask_d;

   assign set_v = set_en ? set_bits : '0;
   assign clr_v = clr_en ? clr_bits : '0;

   generate
      if (CLR_WINS) begin : g_clr_wins
         assign mask_d = (mask_q | set_v) & ~clr_v;
         p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en |=> (mask_q & $past(clr_bits)) == '0);
      end else begin : g_set_wins
         assign mask_d = (mask_q & ~clr_v) | set_v;
         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_en |=> (mask_q & $past(set_bits)) == $past(set_bits));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   p_set_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en && !clr_en |=> (mask_q & $past(set_bits)) == $past(set_bits));
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en && !clr_en |=> $stable(mask_q));
endmodule

// File: rtl/cpi_irq_gate.sv
module cpi_irq_gate #(
   parameter int                NUM_CH  = 8,
   parameter int                KEY_W   = 8,
   parameter logic [KEY_W-1:0]  EOI_KEY = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend,
   input  logic [NUM_CH-1:0] enable,
   input  logic              eoi_en,
   input  logic [KEY_W-1:0]  eoi_key,
   output logic              irq
);
   logic armed_q;
   logic irq_prev_q;
   logic any_live;
   logic key_ok;

   assign any_live = |(pend & enable);
   assign irq      = armed_q & any_live;
   assign key_ok   = eoi_en && (eoi_key == EOI_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b1;
         irq_prev_q <= 1'b0;
      end else begin
         irq_prev_q <= irq;
         if (key_ok)                armed_q <= 1'b1;
         else if (irq_prev_q && !irq) armed_q <= 1'b0;
      end
   end

   p_stay_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q && !key_ok |=> !irq);
   p_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
      key_ok |=> armed_q);
   p_fall_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_prev_q && !irq && !key_ok |=> !irq);
endmodule

// File: rtl/cpi_tracker.sv
module cpi_tracker #(
   parameter int               NUM_CH   = 8,
   parameter int               PTR_W    = 32,
   parameter int               KEY_W    = 8,
   parameter logic [KEY_W-1:0] EOI_KEY  = 8'h01,
   parameter bit               CLR_WINS = 1'b1,
   localparam int              CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_wr_en,
   input  logic [CH_W-1:0]   dma_wr_ch,
   input  logic [PTR_W-1:0]  dma_wr_ptr,
   input  logic              ack_wr_en,
   input  logic [CH_W-1:0]   ack_wr_ch,
   input  logic [PTR_W-1:0]  ack_wr_ptr,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [PTR_W-1:0]  rd_ptr,
   input  logic              mask_set_en,
   input  logic [NUM_CH-1:0] mask_set_bits,
   input  logic              mask_clr_en,
   input  logic [NUM_CH-1:0] mask_clr_bits,
   input  logic              eoi_wr_en,
   input  logic [KEY_W-1:0]  eoi_key,
   output logic [NUM_CH-1:0] pend_raw,
   output logic [NUM_CH-1:0] mask_bits,
   output logic              irq
);
   initial begin
      chk_ch_lo:  assert (NUM_CH >= 2)  else $fatal(1, "NUM_CH must be at least 2");
      chk_ch_hi:  assert (NUM_CH <= 64) else $fatal(1, "NUM_CH must be at most 64");
      chk_ptr_w:  assert (PTR_W >= 1 && PTR_W <= 64) else $fatal(1, "PTR_W out of range");
      chk_key_w:  assert (KEY_W >= 1 && KEY_W <= 32) else $fatal(1, "KEY_W out of range");
   end

   logic [PTR_W-1:0] ptr_arr [NUM_CH];

   cpi_mask_reg #(
      .NUM_CH   (NUM_CH),
      .CLR_WINS (CLR_WINS)
   ) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (mask_set_en),
      .set_bits (mask_set_bits),
      .clr_en   (mask_clr_en),
      .clr_bits (mask_clr_bits),
      .mask_q   (mask_bits)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
         cpi_chan_slot #(
            .PTR_W (PTR_W),
            .CH_W  (CH_W),
            .IDX   (i)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .dma_en  (dma_wr_en),
            .dma_ch  (dma_wr_ch),
            .dma_ptr (dma_wr_ptr),
            .ack_en  (ack_wr_en),
            .ack_ch  (ack_wr_ch),
            .ack_ptr (ack_wr_ptr),
            .enable  (mask_bits[i]),
            .ptr_q   (ptr_arr[i]),
            .pend_q  (pend_raw[i])
         );
      end
   endgenerate

   always_comb begin
      rd_ptr = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_ch == CH_W'(i)) rd_ptr = ptr_arr[i];
      end
   end

   cpi_irq_gate #(
      .NUM_CH  (NUM_CH),
      .KEY_W   (KEY_W),
      .EOI_KEY (EOI_KEY)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend_raw),
      .enable  (mask_bits),
      .eoi_en  (eoi_wr_en),
      .eoi_key (eoi_key),
      .irq     (irq)
   );

   p_mask_no_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_wr_en && !ack_wr_en |=> $stable(pend_raw));
   p_irq_needs_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_raw & mask_bits) != '0);
endmodule

// File: tb/tb_cpi_tracker.sv
`timescale 1ns/1ps
module tb_cpi_tracker;
   localparam int NCH = 8;
   localparam int PW  = 32;
   localparam int KW  = 8;
   localparam logic [KW-1:0] KEY = 8'h01;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_wr_en = 1'b0;
   logic [2:0] dma_wr_ch = '0;
   logic [PW-1:0] dma_wr_ptr = '0;
   logic ack_wr_en = 1'b0;
   logic [2:0] ack_wr_ch = '0;
   logic [PW-1:0] ack_wr_ptr = '0;
   logic [2:0] rd_ch = '0;
   logic [PW-1:0] rd_ptr;
   logic mask_set_en = 1'b0;
   logic [NCH-1:0] mask_set_bits = '0;
   logic mask_clr_en = 1'b0;
   logic [NCH-1:0] mask_clr_bits = '0;
   logic eoi_wr_en = 1'b0;
   logic [KW-1:0] eoi_key = '0;
   logic [NCH-1:0] pend_raw;
   logic [NCH-1:0] mask_bits;
   logic irq;

   always #2.5 clk = ~clk;

   cpi_tracker dut (
      .clk(clk), .rst_n(rst_n),
      .dma_wr_en(dma_wr_en), .dma_wr_ch(dma_wr_ch), .dma_wr_ptr(dma_wr_ptr),
      .ack_wr_en(ack_wr_en), .ack_wr_ch(ack_wr_ch), .ack_wr_ptr(ack_wr_ptr),
      .rd_ch(rd_ch), .rd_ptr(rd_ptr),
      .mask_set_en(mask_set_en), .mask_set_bits(mask_set_bits),
      .mask_clr_en(mask_clr_en), .mask_clr_bits(mask_clr_bits),
      .eoi_wr_en(eoi_wr_en), .eoi_key(eoi_key),
      .pend_raw(pend_raw), .mask_bits(mask_bits), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R1";

   // Behavioural reference model
   logic [PW-1:0] m_ptr [NCH];
   bit [NCH-1:0]  m_pend;
   bit [NCH-1:0]  m_mask;
   bit            m_armed;
   bit            m_prev;

   function automatic bit model_irq();
      return m_armed && ((m_pend & m_mask) != '0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) m_ptr[i] = '0;
         m_pend  = '0;
         m_mask  = '0;
         m_armed = 1'b1;
         m_prev  = 1'b0;
      end else begin
         bit now_irq;
         bit [NCH-1:0] old_mask;
         now_irq  = model_irq();
         old_mask = m_mask;
         if (ack_wr_en && !(dma_wr_en && dma_wr_ch == ack_wr_ch)) begin
            if (ack_wr_ptr == m_ptr[ack_wr_ch]) m_pend[ack_wr_ch] = 1'b0;
         end
         if (dma_wr_en) begin
            m_ptr[dma_wr_ch] = dma_wr_ptr;
            if (old_mask[dma_wr_ch]) m_pend[dma_wr_ch] = 1'b1;
         end
         if (mask_set_en) m_mask = m_mask | mask_set_bits;
         if (mask_clr_en) m_mask = m_mask & ~mask_clr_bits;
         if (eoi_wr_en && eoi_key == KEY) m_armed = 1'b1;
         else if (m_prev && !now_irq)     m_armed = 1'b0;
         m_prev = now_irq;
      end
   end

   task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk({phase, " model pend_raw"}, PW'(pend_raw), PW'(m_pend));
      chk({phase, " model mask_bits"}, PW'(mask_bits), PW'(m_mask));
      chk({phase, " model irq"}, PW'(irq), PW'(model_irq()));
      chk({phase, " model rd_ptr"}, rd_ptr, m_ptr[rd_ch]);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      dma_wr_en = 1'b0; ack_wr_en = 1'b0; mask_set_en = 1'b0;
      mask_clr_en = 1'b0; eoi_wr_en = 1'b0;
      if (rst_n) compare_all();
   endtask

   task automatic dma(input int ch, input logic [PW-1:0] p);
      dma_wr_en = 1'b1; dma_wr_ch = 3'(ch); dma_wr_ptr = p;
   endtask

   task automatic ack(input int ch, input logic [PW-1:0] p);
      ack_wr_en = 1'b1; ack_wr_ch = 3'(ch); ack_wr_ptr = p;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      phase = "R1";
      chk("R1 pend_raw after reset", PW'(pend_raw), 0);
      chk("R1 mask_bits after reset", PW'(mask_bits), 0);
      chk("R1 irq after reset", PW'(irq), 0);
      chk("R1 rd_ptr after reset", rd_ptr, 0);

      phase = "R8";
      mask_set_en = 1'b1; mask_set_bits = 8'hFE; tick();
      chk("R8 set enables", PW'(mask_bits), 32'hFE);
      mask_set_en = 1'b1; mask_set_bits = 8'h02;
      mask_clr_en = 1'b1; mask_clr_bits = 8'h02; tick();
      chk("R8 clear wins", PW'(mask_bits), 32'hFC);
      mask_set_en = 1'b1; mask_set_bits = 8'h02; tick();

      phase = "R2";
      rd_ch = 3'd3; dma(3, 32'h0000_1000); tick();
      chk("R2 pointer stored", rd_ptr, 32'h0000_1000);
      chk("R3 pending raised", PW'(pend_raw[3]), 1);
      chk("R9 irq high", PW'(irq), 1);

      phase = "R4";
      rd_ch = 3'd0; dma(0, 32'h0000_AAAA); tick();
      chk("R4 pointer stored when masked", rd_ptr, 32'h0000_AAAA);
      chk("R4 no pending when masked", PW'(pend_raw[0]), 0);

      phase = "R6";
      rd_ch = 3'd3; ack(3, 32'h0000_0FF0); tick();
      chk("R6 pending kept", PW'(pend_raw[3]), 1);
      chk("R6 pointer kept", rd_ptr, 32'h0000_1000);

      phase = "R3";
      dma(3, 32'h0000_1000); tick();
      chk("R3 same value rewrite keeps pending", PW'(pend_raw[3]), 1);
      dma(3, 32'h0000_1040); tick();
      ack(3, 32'h0000_1000); tick();
      chk("R6 stale ack keeps pending", PW'(pend_raw[3]), 1);

      phase = "R5";
      ack(3, 32'h0000_1040); tick();
      chk("R5 matching ack clears", PW'(pend_raw[3]), 0);
      chk("R5 pointer unchanged", rd_ptr, 32'h0000_1040);
      chk("R9 irq low", PW'(irq), 0);

      phase = "R10";
      dma(5, 32'h0000_2000); tick();
      chk("R10 pending set while disarmed", PW'(pend_raw[5]), 1);
      chk("R10 irq blocked", PW'(irq), 0);
      eoi_wr_en = 1'b1; eoi_key = 8'h02; tick();
      chk("R10 wrong key ignored", PW'(irq), 0);

      phase = "R11";
      eoi_wr_en = 1'b1; eoi_key = KEY; tick();
      chk("R11 rearm raises irq", PW'(irq), 1);

      phase = "R7";
      rd_ch = 3'd5; dma(5, 32'h0000_3000); ack(5, 32'h0000_2000); tick();
      chk("R7 dma wins pointer", rd_ptr, 32'h0000_3000);
      chk("R7 pending stays", PW'(pend_raw[5]), 1);
      dma(5, 32'h0000_3100); ack(5, 32'h0000_3100); tick();
      chk("R7 matching ack dropped", PW'(pend_raw[5]), 1);
      ack(5, 32'h0000_3100); tick();
      chk("R5 clear after collision", PW'(pend_raw[5]), 0);

      phase = "R8b";
      eoi_wr_en = 1'b1; eoi_key = KEY; tick();
      dma(6, 32'h0000_6000); tick();
      chk("R9 irq on ch6", PW'(irq), 1);
      mask_clr_en = 1'b1; mask_clr_bits = 8'h40; tick();
      chk("R8 mask keeps raw pending", PW'(pend_raw[6]), 1);
      chk("R9 masked pending no irq", PW'(irq), 0);

      phase = "RND";
      eoi_wr_en = 1'b1; eoi_key = KEY; tick();
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         rd_ch = 3'($urandom_range(0, 7));
         if (r < 35) dma(int'($urandom_range(0, 7)), 32'($urandom_range(0, 3)));
         if (r >= 20 && r < 60) ack(int'($urandom_range(0, 7)), 32'($urandom_range(0, 3)));
         if (r >= 60 && r < 68) begin mask_set_en = 1'b1; mask_set_bits = 8'($urandom); end
         if (r >= 64 && r < 72) begin mask_clr_en = 1'b1; mask_clr_bits = 8'($urandom); end
         if (r >= 72 && r < 80) begin
            eoi_wr_en = 1'b1;
            eoi_key = ($urandom_range(0, 1) == 0) ? KEY : 8'($urandom_range(2, 255));
         end
         tick();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule